// File: doc/BRIEF.md
# Priority Vector Resolver with Nesting Stack

This block chooses which normal interrupt the processor should take next and returns the handler vector for that source. It receives the per-source pending, enable, fast-forcing, edge-mode and priority values from a neighbouring source bank. A small bus port gives access to a vector table, a spurious vector, a vector-fetch register, a fast-vector register, a current-source status register and an end-of-service register.

A stack of up to eight entries records the sources that are currently in service, together with their priorities. A vector fetch pushes the winning source onto the stack. When the protect input is high, that push moves from the read to a write of the same register, so a debugger can read the register without side effects. An end-of-service write pops one entry. The normal interrupt line is raised only when the best pending request outranks the entry on top of the stack. When a push takes an edge-mode source, or when the fast vector register is read while source 0 is pending, the block pulses a clear request back to the source bank.

Top module: `irq_vector_resolver`

## Requirements
- R1: A source takes part in arbitration only when it is pending and enabled and not fast-forced. Source 0 never takes part.
- R2: Among the candidates, the one with the largest priority value wins. On equal priority, the lower source number wins. With no candidate the winner is 0, which means spurious.
- R3: `irq_o` is high exactly when a candidate exists and either the stack is empty or the priority on top of the stack is strictly below the winner's priority.
- R4: A read at byte address 0x100 returns the winner's vector, or the spurious vector when the winner is 0. The data is valid in the same cycle as the read strobe.
- R5: When `protect_i` is low, a read at 0x100 pushes the winner onto the stack. When `protect_i` is high, reads at 0x100 push nothing and a write at 0x100 pushes the winner instead.
- R6: A push happens only when the winner is not 0 and the stack holds fewer than 8 entries. Pushing a source whose `edge_i` bit is 1 raises that source's bit of `pend_clr_o` in the cycle of the push.
- R7: A write of any value at 0x130 removes the top entry, or does nothing when the stack is empty.
- R8: A read at 0x108 returns the source number on top of the stack, or 0 when the stack is empty.
- R9: A read at 0x104 behaves as follows. If source 0 is pending, it returns vector 0 and raises `pend_clr_o[0]`. Otherwise, if any fast-forced source is pending, it returns vector 0 and clears nothing. Otherwise it returns the spurious vector.
- R10: Source n's vector can be written and read as a word at byte address 0x080 + 4·n. The spurious vector can be written and read at 0x134.
- R11: After reset the stack is empty, all vectors and the spurious vector are zero, and unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NSRC | Pending bit per source |
| mask_i | input | NSRC | Enable bit per source |
| ffrc_i | input | NSRC | Fast-forcing bit per source |
| edge_i | input | NSRC | Edge-mode bit per source |
| prio_i | input | NSRC*PW | Priority per source, source n at bits [n*PW +: PW] |
| protect_i | input | 1 | Moves the stack push from a vector read to a vector write |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | AW | Byte address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational, valid while rd_i is high |
| irq_o | output | 1 | Normal interrupt request line |
| pend_clr_o | output | NSRC | One-cycle request to clear pending bits |

## Verification
`rdata_o`, `irq_o` and `pend_clr_o` are combinational, so their values are due in the same cycle as the inputs or strobe that cause them. Changes to the stack or the vector table take effect at the next rising edge, so they first show up one cycle later. The bench drives inputs on the falling edge and compares against its queue-based model 1 ns later, before the rising edge. Only after that edge does it update the model's stack and tables. In this way every comparison sees the state that the design holds in that cycle.

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver #(
  parameter int NSRC  = 32,
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  parameter int DW    = 32,
  parameter int AW    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   pend_i,
  input  logic [NSRC-1:0]   mask_i,
  input  logic [NSRC-1:0]   ffrc_i,
  input  logic [NSRC-1:0]   edge_i,
  input  logic [NSRC*PW-1:0] prio_i,
  input  logic              protect_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic [NSRC-1:0]   pend_clr_o
);
  localparam int SW  = $clog2(NSRC);
  localparam int IW  = $clog2(DEPTH);
  localparam int DPW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_IVR  = AW'('h100);
  localparam logic [AW-1:0] A_FVR  = AW'('h104);
  localparam logic [AW-1:0] A_STAT = AW'('h108);
  localparam logic [AW-1:0] A_EOI  = AW'('h130);
  localparam logic [AW-1:0] A_SPU  = AW'('h134);

  logic [DW-1:0]  vec_q [NSRC];
  logic [DW-1:0]  spur_q;
  logic [SW-1:0]  stk_src [DEPTH];
  logic [PW-1:0]  stk_pri [DEPTH];
  logic [DPW-1:0] depth_q;

  logic [NSRC-1:0] cand;
  logic [SW-1:0]   win;
  logic [PW-1:0]   wpri;
  logic [IW-1:0]   top_idx, wr_idx;
  logic [SW-1:0]   vidx;
  logic            vec_hit, ivr_rd, ivr_wr, fvr_rd, eoi_wr, spu_wr, push, pop;

  assign cand = pend_i & mask_i & ~ffrc_i & ~NSRC'(1);

  always_comb begin
    win  = '0;
    wpri = '0;
    for (int i = NSRC - 1; i >= 1; i--) begin
      if (cand[i] && prio_i[i*PW +: PW] >= wpri) begin
        win  = SW'(i);
        wpri = prio_i[i*PW +: PW];
      end
    end
  end

  assign top_idx = IW'(depth_q - DPW'(1));
  assign irq_o   = (|cand) && (depth_q == '0 || stk_pri[top_idx] < wpri);

  assign vec_hit = addr_i[AW-1:SW+2] == (AW-SW-2)'(1);
  assign vidx    = addr_i[SW+1:2];
  assign ivr_rd  = rd_i && addr_i == A_IVR;
  assign ivr_wr  = wr_i && addr_i == A_IVR;
  assign fvr_rd  = rd_i && addr_i == A_FVR;
  assign eoi_wr  = wr_i && addr_i == A_EOI;
  assign spu_wr  = wr_i && addr_i == A_SPU;
  assign push    = (protect_i ? ivr_wr : ivr_rd) && win != '0 && depth_q < DPW'(DEPTH);
  assign pop     = eoi_wr && depth_q != '0;
  assign wr_idx  = pop ? top_idx : depth_q[IW-1:0];

  always_comb begin
    pend_clr_o = '0;
    if (push && edge_i[win]) pend_clr_o[win] = 1'b1;
    if (fvr_rd && pend_i[0]) pend_clr_o[0] = 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (vec_hit) rdata_o = vec_q[vidx];
      else case (addr_i)
        A_IVR:  rdata_o = (win == '0) ? spur_q : vec_q[win];
        A_FVR:  rdata_o = (pend_i[0] || |(pend_i & ffrc_i)) ? vec_q[0] : spur_q;
        A_STAT: rdata_o = (depth_q == '0) ? '0 : DW'(stk_src[top_idx]);
        A_SPU:  rdata_o = spur_q;
        default: rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) vec_q[i] <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stk_src[i] <= '0;
        stk_pri[i] <= '0;
      end
      spur_q  <= '0;
      depth_q <= '0;
    end else begin
      if (wr_i && vec_hit) vec_q[vidx] <= wdata_i;
      if (spu_wr) spur_q <= wdata_i;
      if (push) begin
        stk_src[wr_idx] <= win;
        stk_pri[wr_idx] <= wpri;
      end
      depth_q <= depth_q + DPW'(push) - DPW'(pop);
    end
  end

  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DPW'(DEPTH));
  assert_pop_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && depth_q != '0 && !push) |=> depth_q == $past(depth_q) - DPW'(1));
  assert_push_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> stk_src[top_idx] == $past(win));
  assert_spur_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ivr_rd && win == '0) |-> rdata_o == spur_q);
  assert_clr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr_o));
  assert_irq_needs_cand_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> win != '0);
endmodule

// File: tb/irq_vector_resolver_bench.sv
module irq_vector_resolver_bench;
  localparam int A_VEC = 'h080, A_IVR = 'h100, A_FVR = 'h104, A_STAT = 'h108,
                 A_EOI = 'h130, A_SPU = 'h134;

  logic clk = 0, rst_n = 0;
  logic [31:0] pend = 0, mask = 0, ff = 0, edg = 0;
  int          pri [32];
  logic [95:0] prio;
  logic        prot = 0, rd = 0, wr = 0;
  logic [8:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, clr;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] mvec [32];
  logic [31:0] mspur;
  int qs[$], qp[$];

  always #5 clk = ~clk;

  always_comb for (int i = 0; i < 32; i++) prio[i*3 +: 3] = pri[i][2:0];

  irq_vector_resolver u_irq_vector_resolver (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .ffrc_i(ff),
    .edge_i(edg), .prio_i(prio), .protect_i(prot), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pend_clr_o(clr));

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    int bw, bp;
    logic [31:0] er, ec;
    bit ei, dopush;
    #1;
    bw = 0; bp = -1;
    for (int i = 1; i < 32; i++)
      if (pend[i] && mask[i] && !ff[i] && pri[i] > bp) begin bw = i; bp = pri[i]; end
    ei = (bw != 0) && (qp.size() == 0 || qp[$] < bp);
    dopush = ((rd && addr == A_IVR && !prot) || (wr && addr == A_IVR && prot))
             && bw != 0 && qs.size() < 8;
    er = 0; ec = 0;
    if (dopush && edg[bw]) ec[bw] = 1'b1;
    if (rd && addr == A_FVR && pend[0]) ec[0] = 1'b1;
    if (rd) begin
      if (addr >= A_VEC && addr < A_VEC + 128) er = mvec[(addr - A_VEC) >> 2];
      else if (addr == A_IVR) er = (bw == 0) ? mspur : mvec[bw];
      else if (addr == A_FVR) er = (pend[0] || (pend & ff) != 0) ? mvec[0] : mspur;
      else if (addr == A_STAT) er = (qs.size() == 0) ? 0 : qs[$];
      else if (addr == A_SPU) er = mspur;
      check(tag, "rdata", rdata, er);
    end
    check(tag, "irq", {31'b0, irq}, {31'b0, ei});
    check(tag, "pend_clr", clr, ec);
    @(posedge clk);
    if (wr) begin
      if (addr >= A_VEC && addr < A_VEC + 128) mvec[(addr - A_VEC) >> 2] = wdata;
      else if (addr == A_SPU) mspur = wdata;
      else if (addr == A_EOI && qs.size() > 0) begin void'(qs.pop_back()); void'(qp.pop_back()); end
    end
    if (dopush) begin qs.push_back(bw); qp.push_back(bp); end
    @(negedge clk);
    rd = 0; wr = 0;
  endtask

  task automatic rdc(input int a, input string tag);
    addr = 9'(a); rd = 1; cyc(tag);
  endtask

  task automatic wrc(input int a, input logic [31:0] d, input string tag);
    addr = 9'(a); wdata = d; wr = 1; cyc(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin pri[i] = 0; mvec[i] = 0; end
    mspur = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rdc(A_STAT, "R11"); rdc(A_SPU, "R11"); rdc(A_IVR, "R11"); rdc(A_VEC + 8, "R11");
    rdc('h1F0, "R11");

    for (int i = 0; i < 32; i++) wrc(A_VEC + 4*i, 32'hC0DE_0000 | i, "R10");
    wrc(A_SPU, 32'h5EED_BEEF, "R10");
    rdc(A_VEC, "R10"); rdc(A_VEC + 4*17, "R10"); rdc(A_VEC + 124, "R10"); rdc(A_SPU, "R10");

    pri[3] = 2; pri[5] = 5; pri[9] = 5; pri[12] = 7; pri[20] = 5; pri[7] = 6;
    mask = '1;
    pend = 0; pend[0] = 1;
    rdc(A_IVR, "R1");
    pend = 0; pend[3] = 1; pend[5] = 1; pend[9] = 1;
    cyc("R3");
    rdc(A_IVR, "R2");
    rdc(A_STAT, "R8");
    cyc("R3");
    pend[12] = 1; cyc("R3");
    ff[12] = 1; cyc("R1");
    rdc(A_IVR, "R1");
    ff = 0;
    rdc(A_IVR, "R5");
    rdc(A_STAT, "R8");
    wrc(A_EOI, 32'h0, "R7"); rdc(A_STAT, "R7");
    wrc(A_EOI, 32'h1234, "R7"); wrc(A_EOI, 32'h0, "R7"); rdc(A_STAT, "R7");

    pend = 0; pend[9] = 1; edg[9] = 1;
    rdc(A_IVR, "R6");
    pend[9] = 0; rdc(A_STAT, "R6");
    wrc(A_EOI, 0, "R7");
    edg = 0;

    pend = 0; pend[20] = 1;
    for (int k = 0; k < 10; k++) rdc(A_IVR, "R6");
    rdc(A_STAT, "R6");
    pend[12] = 1; cyc("R3");
    pend[12] = 0;
    for (int k = 0; k < 9; k++) wrc(A_EOI, 0, "R7");
    rdc(A_STAT, "R7");

    prot = 1;
    rdc(A_IVR, "R5"); rdc(A_STAT, "R5");
    wrc(A_IVR, 0, "R5"); rdc(A_STAT, "R5");
    prot = 0;
    wrc(A_EOI, 0, "R7");

    mask[20] = 0; rdc(A_IVR, "R1"); rdc(A_STAT, "R1");
    mask = '1;

    pend = 0; pend[0] = 1; rdc(A_FVR, "R9");
    pend = 0; pend[7] = 1; ff[7] = 1; rdc(A_FVR, "R9");
    pend = 0; rdc(A_FVR, "R9");
    ff = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule